// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address (a segment number and an offset within that segment) into a physical address. Before it reads memory, it compares the segment number with a length register. It then fetches the segment's descriptor from a table in memory. The table's start address is held in a base register, and each descriptor occupies three consecutive words. The descriptor supplies a physical start address, a segment length and a set of flags. The block checks the offset against the length, checks that the segment is marked present, and checks that the access type is allowed by the flags. It then returns either the translated address or a trap with a cause code.

Translation requests enter through a valid/ready stream and results leave through a valid/ready stream. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. A result stays presented, unchanged, until `rsp_ready` is seen high. Descriptor reads use a request/response memory port. Each read request is held steady until `mem_req_ready` accepts it. The memory returns exactly one `mem_rsp_valid` pulse per accepted read, in order. The table base and table length registers are loaded through a plain privileged write port.

Top module: `segx_top`

## Requirements
- R1: Only one translation is in flight at a time. `req_ready` is high only while no translation is pending. `busy` is high from the cycle after a request is accepted until the result appears on `rsp_valid`, and it is low while the result is presented.
- R2: A segment number greater than or equal to the table length register produces a trap with cause 0 and issues no memory read.
- R3: For a legal segment s, three word reads are issued in order, at table_base + 12·s + 0, +4 and +8. Word 0 is the segment's physical base. Word 1 is its length (limit). In word 2, bit 0 is the present flag, bit 1 allows read, bit 2 allows write and bit 3 allows execute.
- R4: A descriptor whose present bit is 0 produces a trap with cause 1.
- R5: An offset greater than or equal to the limit produces a trap with cause 2. An offset of limit−1 is accepted.
- R6: The access type is coded as 0 = read, 1 = write, 2 = execute and 3 = reserved. A type whose permission bit is 0, or the reserved type, produces a trap with cause 3.
- R7: When several checks fail, the reported cause is the lowest-numbered of causes 0 to 3.
- R8: When no check fails, `rsp_trap` is 0, `rsp_cause` is 0, and `rsp_paddr` equals the descriptor base plus the zero-extended offset, taken modulo 2^ADDR_W.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the result fields stay unchanged.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the read request and its address stay unchanged.
- R11: A write with `cfg_sel`=0 loads the table base register, and a write with `cfg_sel`=1 loads the table length register. Both registers reset to 0, so every translation before the first configuration write traps with cause 0. New values apply to translations accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Privileged register write strobe |
| cfg_sel | input | 1 | 0 = table base, 1 = table length |
| cfg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access type |
| busy | output | 1 | Translation in progress |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer accepts result |
| rsp_trap | output | 1 | Translation faulted |
| rsp_cause | output | 2 | Trap cause code |
| rsp_paddr | output | ADDR_W | Physical address (0 on trap) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Byte address of descriptor word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | ADDR_W | Read data |

## Verification
The hardest situations to reach are descriptors that fail two checks at once. In those cases only the cause ordering decides what is reported. The table therefore holds a non-present segment whose permission bits are set, and requests are aimed at it with offsets that also exceed its limit. A second set of requests fails both the limit and the permission check. Memory stalls in the middle of a fetch are also hard to reach. The memory model drops `mem_req_ready` one cycle in four, so reads stall at varying points inside the three-word fetch. Separately, the result port is held off for several cycles to exercise stalls at the output.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [1:0] {
    CAUSE_RANGE   = 2'd0,
    CAUSE_INVALID = 2'd1,
    CAUSE_LIMIT   = 2'd2,
    CAUSE_PERM    = 2'd3
  } segx_cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } segx_acc_e;

  // descriptor flag word bit positions
  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_RD      = 1;
  localparam int FLAG_WR      = 2;
  localparam int FLAG_EX      = 3;
  localparam int FLAG_BITS    = 4;

  // descriptor word order
  localparam int DW_BASE  = 0;
  localparam int DW_LIMIT = 1;
  localparam int DW_FLAGS = 2;
  localparam int DESC_WORDS = 3;
endpackage

// File: rtl/segx_cfg.sv
module segx_cfg #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] tbl_base_o,
  output logic [SEG_W:0]    tbl_len_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base_o <= '0;
      tbl_len_o  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) tbl_len_o  <= cfg_wdata[SEG_W:0];
      else         tbl_base_o <= cfg_wdata;
    end
  end

  logic unused_cfg_hi;
  assign unused_cfg_hi = ^cfg_wdata[ADDR_W-1:SEG_W+1];
endmodule

// File: rtl/segx_fetch.sv
module segx_fetch
  import segx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [SEG_W-1:0]             seg_i,
  input  logic [ADDR_W-1:0]            tbl_base_i,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-1:0]            mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [ADDR_W-1:0]            mem_rsp_data,
  output logic                         done_o,
  output logic [DESC_WORDS*ADDR_W-1:0] words_o
);
  localparam int WORD_BYTES = ADDR_W / 8;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
  localparam int IDX_W      = $clog2(DESC_WORDS + 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_DONE} fst_e;
  fst_e             st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] rsp_cnt_q;
  logic [ADDR_W-1:0] desc_addr_q;
  logic              last_word;

  assign last_word     = (idx_q == IDX_W'(DESC_WORDS - 1));
  assign mem_req_valid = (st_q == F_REQ);
  assign mem_req_addr  = desc_addr_q + ADDR_W'(idx_q) * ADDR_W'(WORD_BYTES);
  assign done_o        = (st_q == F_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= F_IDLE;
      idx_q       <= '0;
      rsp_cnt_q   <= '0;
      desc_addr_q <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: if (start_i) begin
          desc_addr_q <= tbl_base_i + ADDR_W'(seg_i) * ADDR_W'(DESC_BYTES);
          idx_q       <= '0;
          rsp_cnt_q   <= '0;
          st_q        <= F_REQ;
        end
        F_REQ: if (mem_req_ready) st_q <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          rsp_cnt_q <= rsp_cnt_q + 1'b1;
          if (last_word) st_q <= F_DONE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= F_REQ;
          end
        end
        F_DONE: st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  // one capture register per descriptor word
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic [ADDR_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (st_q == F_WAIT && mem_rsp_valid && idx_q == IDX_W'(g))
        word_q <= mem_rsp_data;
    end
    assign words_o[g*ADDR_W +: ADDR_W] = word_q;
  end

  // R10: a stalled read holds its address
  assert_memreq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3: completion only after every descriptor word returned
  assert_all_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> rsp_cnt_q == IDX_W'(DESC_WORDS));
endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 8,
  parameter int OFF_W  = 16
) (
  input  logic [SEG_W-1:0]             seg_i,
  input  logic [SEG_W:0]               tbl_len_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic [1:0]                   acc_i,
  input  logic [DESC_WORDS*ADDR_W-1:0] words_i,
  output logic                         range_ok_o,
  output logic                         trap_o,
  output segx_cause_e                  cause_o,
  output logic [ADDR_W-1:0]            paddr_o
);
  logic [ADDR_W-1:0] base, limit, flag_word, off_ext;
  logic present, in_limit, allowed;

  assign base      = words_i[DW_BASE*ADDR_W  +: ADDR_W];
  assign limit     = words_i[DW_LIMIT*ADDR_W +: ADDR_W];
  assign flag_word = words_i[DW_FLAGS*ADDR_W +: ADDR_W];
  assign off_ext   = ADDR_W'(off_i);

  assign range_ok_o = ({1'b0, seg_i} < tbl_len_i);
  assign present    = flag_word[FLAG_PRESENT];
  assign in_limit   = off_ext < limit;

  always_comb begin
    unique case (segx_acc_e'(acc_i))
      ACC_READ:  allowed = flag_word[FLAG_RD];
      ACC_WRITE: allowed = flag_word[FLAG_WR];
      ACC_EXEC:  allowed = flag_word[FLAG_EX];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    trap_o  = 1'b1;
    cause_o = CAUSE_RANGE;
    if (!range_ok_o)    cause_o = CAUSE_RANGE;
    else if (!present)  cause_o = CAUSE_INVALID;
    else if (!in_limit) cause_o = CAUSE_LIMIT;
    else if (!allowed)  cause_o = CAUSE_PERM;
    else                trap_o  = 1'b0;
  end

  assign paddr_o = trap_o ? '0 : base + off_ext;

  logic unused_flag_hi;
  assign unused_flag_hi = ^flag_word[ADDR_W-1:FLAG_BITS];
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 8,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              busy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_trap,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_RANGE, S_FETCH, S_DONE} st_e;
  st_e st_q;

  logic [ADDR_W-1:0] tbl_base;
  logic [SEG_W:0]    tbl_len;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic              trap_q, fetched_q;
  segx_cause_e       cause_q;
  logic [ADDR_W-1:0] paddr_q;

  logic                         fetch_start, fetch_done, range_ok, chk_trap;
  logic [DESC_WORDS*ADDR_W-1:0] words;
  segx_cause_e                  chk_cause;
  logic [ADDR_W-1:0]            chk_paddr;

  segx_cfg #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tbl_base_o(tbl_base), .tbl_len_o(tbl_len)
  );

  assign fetch_start = (st_q == S_RANGE) && range_ok;

  segx_fetch #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(fetch_start), .seg_i(seg_q),
    .tbl_base_i(tbl_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_o(fetch_done), .words_o(words)
  );

  segx_check #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_check (
    .seg_i(seg_q), .tbl_len_i(tbl_len), .off_i(off_q), .acc_i(acc_q),
    .words_i(words), .range_ok_o(range_ok), .trap_o(chk_trap),
    .cause_o(chk_cause), .paddr_o(chk_paddr)
  );

  assign req_ready = (st_q == S_IDLE);
  assign busy      = (st_q == S_RANGE) || (st_q == S_FETCH);
  assign rsp_valid = (st_q == S_DONE);
  assign rsp_trap  = trap_q;
  assign rsp_cause = cause_q;
  assign rsp_paddr = paddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      seg_q     <= '0;
      off_q     <= '0;
      acc_q     <= '0;
      trap_q    <= 1'b0;
      cause_q   <= CAUSE_RANGE;
      paddr_q   <= '0;
      fetched_q <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) fetched_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          seg_q     <= req_seg;
          off_q     <= req_off;
          acc_q     <= req_acc;
          fetched_q <= 1'b0;
          st_q      <= S_RANGE;
        end
        S_RANGE: if (!range_ok) begin
          trap_q  <= 1'b1;
          cause_q <= CAUSE_RANGE;
          paddr_q <= '0;
          st_q    <= S_DONE;
        end else begin
          st_q <= S_FETCH;
        end
        S_FETCH: if (fetch_done) begin
          trap_q  <= chk_trap;
          cause_q <= chk_cause;
          paddr_q <= chk_paddr;
          st_q    <= S_DONE;
        end
        S_DONE: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R1: no new request while a translation is pending
  assert_single_flight_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  assert_busy_before_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(busy));

  // R2: an out-of-range trap never touched memory
  assert_range_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap && rsp_cause == 2'd0 |-> !fetched_q);

  // R9: stalled result holds
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_trap) && $stable(rsp_cause));
endmodule

// File: tb/sim_segx_top.sv
`timescale 1ns/1ps
module sim_segx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0, req_ready;
  logic [7:0]  req_seg = 0;
  logic [15:0] req_off = 0;
  logic [1:0]  req_acc = 0;
  logic        busy, rsp_valid, rsp_ready = 0, rsp_trap;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  segx_top u0 (.*);

  int checks = 0, failures = 0;
  logic [31:0] mem [0:63];
  logic [31:0] alog [0:63];
  int nreq = 0;
  logic [7:0] rdy_cnt = 0;

  // memory model: one stalled cycle in four, one-cycle read latency
  always @(posedge clk) begin
    rdy_cnt       <= rdy_cnt + 1;
    mem_req_ready <= (rdy_cnt[1:0] != 2'd2);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid     <= 1'b1;
      mem_rsp_data      <= mem[mem_req_addr[7:2]];
      alog[nreq % 64]   <= mem_req_addr;
      nreq              <= nreq + 1;
    end
  end

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // issue one translation; hold the result back for 'hold' cycles
  task automatic xlate(input logic [7:0] s, input logic [15:0] o, input logic [1:0] a,
                       input int hold, output logic [31:0] pa, output logic tr,
                       output logic [1:0] ca, output int nr, output logic [31:0] a0);
    int start;
    logic busy_ok;
    start = nreq;
    busy_ok = 1'b1;
    @(negedge clk);
    req_valid = 1; req_seg = s; req_off = o; req_acc = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) begin
      if (!busy || req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    if (busy) busy_ok = 1'b0;
    chk(busy_ok, "R1 busy/ready during translation", {30'd0, busy, req_ready}, 32'd0);
    pa = rsp_paddr; tr = rsp_trap; ca = rsp_cause;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa && rsp_trap == tr && rsp_cause == ca,
          "R9 result stable under back-pressure", rsp_paddr, pa);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    nr = nreq - start;
    a0 = alog[start % 64];
  endtask

  task automatic expect_trap(input string rq, input logic [7:0] s, input logic [15:0] o,
                             input logic [1:0] a, input logic [1:0] cause);
    logic [31:0] pa, a0; logic tr; logic [1:0] ca; int nr;
    xlate(s, o, a, 0, pa, tr, ca, nr, a0);
    chk(tr == 1'b1 && ca == cause, rq, {29'd0, tr, ca}, {29'd0, 1'b1, cause});
    if (cause == 2'd0) chk(nr == 0, "R2 no memory read on range trap", nr, 0);
  endtask

  task automatic expect_ok(input string rq, input logic [7:0] s, input logic [15:0] o,
                           input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] pa, a0; logic tr; logic [1:0] ca; int nr;
    xlate(s, o, a, 0, pa, tr, ca, nr, a0);
    chk(!tr && ca == 2'd0 && pa == exp, rq, pa, exp);
  endtask

  task automatic t_reset;
    chk(req_ready && !busy && !rsp_valid && !mem_req_valid, "R1 reset idle state",
        {28'd0, req_ready, busy, rsp_valid, mem_req_valid}, 32'h8);
    expect_trap("R11 length register resets to zero", 8'd0, 16'd0, 2'd0, 2'd0);
  endtask

  task automatic t_range;
    expect_trap("R2 segment equal to length", 8'd4, 16'd0, 2'd0, 2'd0);
    expect_trap("R2 segment far above length", 8'd255, 16'd0, 2'd1, 2'd0);
  endtask

  task automatic t_fetch_order;
    logic [31:0] pa, a0; logic tr; logic [1:0] ca; int nr; int st;
    st = nreq;
    xlate(8'd1, 16'h10, 2'd0, 0, pa, tr, ca, nr, a0);
    chk(nr == 3, "R3 three descriptor reads", nr, 3);
    chk(alog[st % 64] == 32'h1C && alog[(st+1) % 64] == 32'h20 && alog[(st+2) % 64] == 32'h24,
        "R3 descriptor word addresses", alog[(st+2) % 64], 32'h24);
    chk(!tr && pa == 32'h2010, "R8 translated address", pa, 32'h2010);
  endtask

  task automatic t_limit;
    expect_ok("R5 offset limit-1 accepted", 8'd1, 16'h3F, 2'd1, 32'h203F);
    expect_trap("R5 offset equal to limit", 8'd1, 16'h40, 2'd0, 2'd2);
  endtask

  task automatic t_invalid;
    expect_trap("R4 non-present segment", 8'd2, 16'd0, 2'd0, 2'd1);
  endtask

  task automatic t_perm;
    expect_trap("R6 write to read/exec segment", 8'd0, 16'd4, 2'd1, 2'd3);
    expect_trap("R6 exec on read/write segment", 8'd1, 16'd4, 2'd2, 2'd3);
    expect_ok("R6 exec allowed", 8'd0, 16'd0, 2'd2, 32'h1000);
    expect_trap("R6 reserved access type", 8'd3, 16'd0, 2'd3, 2'd3);
  endtask

  task automatic t_priority;
    expect_trap("R7 invalid beats limit", 8'd2, 16'h900, 2'd1, 2'd1);
    expect_trap("R7 limit beats permission", 8'd1, 16'h50, 2'd2, 2'd2);
  endtask

  task automatic t_wrap;
    expect_ok("R8 address wraps modulo 2^32", 8'd3, 16'h180, 2'd2, 32'h80);
  endtask

  task automatic t_backpressure;
    logic [31:0] pa, a0; logic tr; logic [1:0] ca; int nr;
    xlate(8'd0, 16'h20, 2'd0, 5, pa, tr, ca, nr, a0);
    chk(!tr && pa == 32'h1020, "R9 held result value", pa, 32'h1020);
    xlate(8'd1, 16'h99, 2'd0, 3, pa, tr, ca, nr, a0);
    chk(tr && ca == 2'd2, "R9 held trap value", {30'd0, ca}, 32'd2);
    chk(nr == 3, "R10 stalled reads each accepted once", nr, 3);
  endtask

  task automatic t_cfg;
    cfg_write(1'b1, 32'd2);
    expect_trap("R11 shortened table length", 8'd2, 16'd0, 2'd0, 2'd0);
    cfg_write(1'b0, 32'h1C);
    expect_ok("R11 moved table base", 8'd0, 16'h8, 2'd0, 32'h2008);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // table at 0x10, 12 bytes per descriptor: base, limit, flags
    mem[4]  = 32'h0000_1000; mem[5]  = 32'h100;  mem[6]  = 32'hB;
    mem[7]  = 32'h0000_2000; mem[8]  = 32'h40;   mem[9]  = 32'h7;
    mem[10] = 32'h0000_3000; mem[11] = 32'h800;  mem[12] = 32'hE;
    mem[13] = 32'hFFFF_FF00; mem[14] = 32'h1000; mem[15] = 32'hF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    cfg_write(1'b0, 32'h10);
    cfg_write(1'b1, 32'd4);
    t_range;
    t_fetch_order;
    t_limit;
    t_invalid;
    t_perm;
    t_priority;
    t_wrap;
    t_backpressure;
    t_cfg;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule